// File: doc/BRIEF.md
# Triple-Buffer Frame Store Address Controller

This block sits between a pixel stream and external memory in a video pipeline and turns pixels into byte addresses for a set of three frame buffers. A write channel accepts 24-bit pixels on an AXI4-Stream style input. On that input, `tuser` flags the first pixel of a frame and `tlast` flags the last pixel of a line. For every pixel the write channel issues one write request carrying the pixel and its byte address. A read channel independently produces the byte addresses from which a display path fetches a frame. Both channels use a simple valid/ready request port. Bursts, the memory protocol and the memory itself lie outside the block.

Each channel has its own run enable and its own settings:

- three buffer base addresses, typically 0x01000000, 0x02000000 and 0x03000000;
- the active line length in bytes, for example 1920 for 640 pixels of 3 bytes;
- a stride, which is the byte distance between the start addresses of consecutive lines and is set apart from the line length (0x780 for the frame above);
- the number of lines per frame, for example 480.

The writer cycles through the buffers one frame after another. The reader is slaved to the writer: at the start of each of its frames it takes the buffer the writer finished most recently. The writer never enters the buffer the reader holds, and never enters the buffer it has just completed. As a result, the two channels are never on the same frame and the picture does not tear.

Top module: `fbuf_addr_ctrl`

## Requirements
- R1: Exactly three buffers are used. With no reader active, the writer's successive frames go to buffer 0, 1, 2, 0, … in that order, starting from buffer 0 after reset.
- R2: A write frame opens only on an accepted beat with `vin_tuser` high while `wr_run` is high. Outside a frame, beats are accepted (`vin_tready` high), and they produce no write request.
- R3: The write address of a pixel is the buffer base plus line index times stride plus pixel index times 3. The first pixel of a frame is written at the selected base.
- R4: `vin_tlast` ends a line. The frame completes on the `tlast` beat of line number (line count − 1), counted from 0.
- R5: `wr_len_err` goes high and stays high until reset when a `tlast` beat's byte count (pixel index + 1) × 3 differs from the programmed line length.
- R6: The reader starts a frame only when `rd_run` is high and at least one write frame has completed. At its start it locks the most recently completed buffer.
- R7: While the reader holds buffer B, the writer's next buffer is the one after the last completed buffer in rotation order, skipping B. The two channels never work in the same buffer.
- R8: Read addresses follow base + line × stride + pixel × 3. `rreq_sof` marks line 0, pixel 0. `rreq_eol` marks the pixel whose byte end reaches the line length. The address is held while `rreq_valid` is high and `rreq_ready` is low.
- R9: The line length, stride and line count are captured at a frame start. Changes made during a frame take effect from the next frame.
- R10: The two run bits act independently. With `wr_run` low, a `tuser` beat opens no frame and produces no writes. With `rd_run` low, no read frame starts.
- R11: A `tuser` beat in the middle of a frame restarts the writer at line 0. The abandoned frame does not count as completed, so the restart reuses the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_run | input | 1 | Write channel run enable |
| wr_base | input | NBUF×ADDR_W | Write buffer base addresses |
| wr_line_bytes | input | LEN_W | Write active line length in bytes |
| wr_stride | input | LEN_W | Write byte distance between line starts |
| wr_lines | input | LINE_W | Write lines per frame |
| vin_tvalid | input | 1 | Pixel stream valid |
| vin_tready | output | 1 | Pixel stream ready |
| vin_tdata | input | PIX_W | Pixel, 3 bytes |
| vin_tuser | input | 1 | First pixel of frame |
| vin_tlast | input | 1 | Last pixel of line |
| wreq_valid | output | 1 | Write request valid |
| wreq_ready | input | 1 | Write request accepted |
| wreq_addr | output | ADDR_W | Write byte address |
| wreq_data | output | PIX_W | Write pixel |
| wr_len_err | output | 1 | Sticky line-length error |
| rd_run | input | 1 | Read channel run enable |
| rd_base | input | NBUF×ADDR_W | Read buffer base addresses |
| rd_line_bytes | input | LEN_W | Read active line length in bytes |
| rd_stride | input | LEN_W | Read byte distance between line starts |
| rd_lines | input | LINE_W | Read lines per frame |
| rreq_valid | output | 1 | Read address valid |
| rreq_ready | input | 1 | Read address accepted |
| rreq_addr | output | ADDR_W | Read byte address |
| rreq_sof | output | 1 | Read address is frame start |
| rreq_eol | output | 1 | Read address is last of line |

## Verification
The bench uses a small frame of 4 pixels per line, 3 lines, and a stride of 0x20 that is wider than the line.

- Back-to-back frames with the reader idle separate a correct rotation from one that reuses a buffer. The stride also shows whether the line step uses the stride or the line length.
- A stride change in the middle of a frame, and a restart in the middle of a frame, show whether settings and the buffer choice are captured only at frame starts.
- Write frames sent while the reader is stalled on its buffer show whether the writer skips the held buffer. Reads with a ready that toggles show whether addresses are held under backpressure.
- A frame with short lines must raise the error flag, and the flag must survive a following clean frame.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
   typedef logic [1:0] buf_idx_t;

   localparam int unsigned BYTES_PER_PIX = 3;
   localparam int unsigned NUM_BUFS      = 3;

   // step one position forward in the three-entry rotation
   function automatic buf_idx_t buf_inc(input buf_idx_t i);
      return (i == buf_idx_t'(NUM_BUFS - 1)) ? buf_idx_t'(0) : i + buf_idx_t'(1);
   endfunction
endpackage

// File: rtl/fbuf_sel.sv
module fbuf_sel
   import fbuf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_done,
   input  buf_idx_t wr_done_idx,
   input  logic     rd_busy,
   input  buf_idx_t rd_idx,
   output buf_idx_t wr_next,
   output buf_idx_t last_done,
   output logic     done_vld
);
   buf_idx_t last_q;
   logic     vld_q;
   buf_idx_t cand;

   // last_q starts at the final index so that the first frame goes to buffer 0
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= buf_idx_t'(NUM_BUFS - 1);
         vld_q  <= 1'b0;
      end else if (wr_done) begin
         last_q <= wr_done_idx;
         vld_q  <= 1'b1;
      end
   end

   always_comb begin
      cand = buf_inc(last_q);
      if (rd_busy && (cand == rd_idx)) cand = buf_inc(cand);
   end

   assign wr_next   = cand;
   assign last_done = last_q;
   assign done_vld  = vld_q;
endmodule

// File: rtl/fbuf_wr_chan.sv
module fbuf_wr_chan
   import fbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned LINE_W = 12,
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned NBUF   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic [NBUF-1:0][ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]            cfg_len,
   input  logic [LEN_W-1:0]            cfg_stride,
   input  logic [LINE_W-1:0]           cfg_lines,
   input  logic                        s_tvalid,
   output logic                        s_tready,
   input  logic [PIX_W-1:0]            s_tdata,
   input  logic                        s_tuser,
   input  logic                        s_tlast,
   output logic                        mw_valid,
   input  logic                        mw_ready,
   output logic [ADDR_W-1:0]           mw_addr,
   output logic [PIX_W-1:0]            mw_data,
   output logic                        len_err,
   input  buf_idx_t                    next_idx,
   output logic                        done,
   output buf_idx_t                    done_idx,
   output logic                        busy,
   output buf_idx_t                    cur_idx
);
   localparam int unsigned PW = LEN_W + 1;

   logic              in_frame_q, err_q;
   buf_idx_t          idx_q, idx_e;
   logic [LINE_W-1:0] line_q, lines_q, line_e, lines_e;
   logic [LEN_W-1:0]  len_q, stride_q, len_e, stride_e;
   logic [PW-1:0]     pix_q, pix_e, pix_nx;
   logic [ADDR_W-1:0] lbase_q, lbase_e;
   logic              sof, drop, take, acc, len_ok, last_line;

   always_comb begin
      sof       = s_tuser & run;
      drop      = s_tuser ? ~run : ~in_frame_q;
      take      = s_tvalid & ~drop;
      s_tready  = drop | mw_ready;
      acc       = s_tvalid & s_tready;
      // a frame-start beat uses live settings; any other beat uses captured ones
      idx_e     = sof ? next_idx   : idx_q;
      len_e     = sof ? cfg_len    : len_q;
      stride_e  = sof ? cfg_stride : stride_q;
      lines_e   = sof ? cfg_lines  : lines_q;
      line_e    = sof ? '0         : line_q;
      pix_e     = sof ? '0         : pix_q;
      lbase_e   = sof ? base[next_idx] : lbase_q;
      pix_nx    = pix_e + PW'(BYTES_PER_PIX);
      len_ok    = (pix_nx == {1'b0, len_e});
      last_line = (line_e == (lines_e - LINE_W'(1)));
   end

   assign mw_valid = take;
   assign mw_addr  = lbase_e + ADDR_W'(pix_e);
   assign mw_data  = s_tdata;
   assign done     = take & mw_ready & s_tlast & last_line;
   assign done_idx = idx_e;
   assign len_err  = err_q;
   assign busy     = in_frame_q;
   assign cur_idx  = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         err_q      <= 1'b0;
         idx_q      <= '0;
         line_q     <= '0;
         lines_q    <= '0;
         len_q      <= '0;
         stride_q   <= '0;
         pix_q      <= '0;
         lbase_q    <= '0;
      end else if (acc) begin
         if (drop) begin
            in_frame_q <= 1'b0;
         end else begin
            idx_q    <= idx_e;
            len_q    <= len_e;
            stride_q <= stride_e;
            lines_q  <= lines_e;
            if (s_tlast) begin
               if (!len_ok) err_q <= 1'b1;
               if (last_line) begin
                  in_frame_q <= 1'b0;
               end else begin
                  in_frame_q <= 1'b1;
                  line_q     <= line_e + LINE_W'(1);
                  lbase_q    <= lbase_e + ADDR_W'(stride_e);
                  pix_q      <= '0;
               end
            end else begin
               in_frame_q <= 1'b1;
               line_q     <= line_e;
               lbase_q    <= lbase_e;
               pix_q      <= pix_nx;
            end
         end
      end
   end
endmodule

// File: rtl/fbuf_rd_chan.sv
module fbuf_rd_chan
   import fbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned LINE_W = 12,
   parameter int unsigned NBUF   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic [NBUF-1:0][ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]            cfg_len,
   input  logic [LEN_W-1:0]            cfg_stride,
   input  logic [LINE_W-1:0]           cfg_lines,
   input  logic                        avail,
   input  buf_idx_t                    pick_idx,
   output logic                        mr_valid,
   input  logic                        mr_ready,
   output logic [ADDR_W-1:0]           mr_addr,
   output logic                        mr_sof,
   output logic                        mr_eol,
   output logic                        busy,
   output buf_idx_t                    cur_idx
);
   localparam int unsigned PW = LEN_W + 1;

   logic              act_q;
   buf_idx_t          idx_q;
   logic [LINE_W-1:0] line_q, lines_q;
   logic [LEN_W-1:0]  len_q, stride_q;
   logic [PW-1:0]     pix_q, pix_nx;
   logic [ADDR_W-1:0] lbase_q;
   logic              eol, last_line;

   always_comb begin
      pix_nx    = pix_q + PW'(BYTES_PER_PIX);
      eol       = (pix_nx >= {1'b0, len_q});
      last_line = (line_q == (lines_q - LINE_W'(1)));
   end

   assign mr_valid = act_q;
   assign mr_addr  = lbase_q + ADDR_W'(pix_q);
   assign mr_sof   = act_q & (line_q == '0) & (pix_q == '0);
   assign mr_eol   = act_q & eol;
   assign busy     = act_q;
   assign cur_idx  = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         idx_q    <= '0;
         line_q   <= '0;
         lines_q  <= '0;
         len_q    <= '0;
         stride_q <= '0;
         pix_q    <= '0;
         lbase_q  <= '0;
      end else if (!act_q) begin
         if (run && avail) begin
            act_q    <= 1'b1;
            idx_q    <= pick_idx;
            lbase_q  <= base[pick_idx];
            pix_q    <= '0;
            line_q   <= '0;
            len_q    <= cfg_len;
            stride_q <= cfg_stride;
            lines_q  <= cfg_lines;
         end
      end else if (mr_ready) begin
         if (eol) begin
            if (last_line) begin
               act_q <= 1'b0;
            end else begin
               line_q  <= line_q + LINE_W'(1);
               lbase_q <= lbase_q + ADDR_W'(stride_q);
               pix_q   <= '0;
            end
         end else begin
            pix_q <= pix_nx;
         end
      end
   end
endmodule

// File: rtl/fbuf_addr_ctrl.sv
module fbuf_addr_ctrl
   import fbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned LINE_W = 12,
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned NBUF   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_run,
   input  logic [NBUF-1:0][ADDR_W-1:0] wr_base,
   input  logic [LEN_W-1:0]            wr_line_bytes,
   input  logic [LEN_W-1:0]            wr_stride,
   input  logic [LINE_W-1:0]           wr_lines,
   input  logic                        vin_tvalid,
   output logic                        vin_tready,
   input  logic [PIX_W-1:0]            vin_tdata,
   input  logic                        vin_tuser,
   input  logic                        vin_tlast,
   output logic                        wreq_valid,
   input  logic                        wreq_ready,
   output logic [ADDR_W-1:0]           wreq_addr,
   output logic [PIX_W-1:0]            wreq_data,
   output logic                        wr_len_err,
   input  logic                        rd_run,
   input  logic [NBUF-1:0][ADDR_W-1:0] rd_base,
   input  logic [LEN_W-1:0]            rd_line_bytes,
   input  logic [LEN_W-1:0]            rd_stride,
   input  logic [LINE_W-1:0]           rd_lines,
   output logic                        rreq_valid,
   input  logic                        rreq_ready,
   output logic [ADDR_W-1:0]           rreq_addr,
   output logic                        rreq_sof,
   output logic                        rreq_eol
);
   generate
      if (NBUF != NUM_BUFS) begin : g_bad_nbuf
         $error("fbuf_addr_ctrl: NBUF must be 3");
      end
      if (PIX_W != 8 * BYTES_PER_PIX) begin : g_bad_pix
         $error("fbuf_addr_ctrl: PIX_W must be 24");
      end
      if (LEN_W > ADDR_W) begin : g_bad_len
         $error("fbuf_addr_ctrl: LEN_W must not exceed ADDR_W");
      end
   endgenerate

   buf_idx_t wr_next_w, last_done_w, done_idx_w, wr_idx_w, rd_idx_w;
   logic     wr_done_w, done_vld_w, wr_busy_w, rd_busy_w;

   fbuf_sel u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_done     (wr_done_w),
      .wr_done_idx (done_idx_w),
      .rd_busy     (rd_busy_w),
      .rd_idx      (rd_idx_w),
      .wr_next     (wr_next_w),
      .last_done   (last_done_w),
      .done_vld    (done_vld_w)
   );

   fbuf_wr_chan #(
      .ADDR_W (ADDR_W), .LEN_W (LEN_W), .LINE_W (LINE_W), .PIX_W (PIX_W), .NBUF (NBUF)
   ) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (wr_run),
      .base       (wr_base),
      .cfg_len    (wr_line_bytes),
      .cfg_stride (wr_stride),
      .cfg_lines  (wr_lines),
      .s_tvalid   (vin_tvalid),
      .s_tready   (vin_tready),
      .s_tdata    (vin_tdata),
      .s_tuser    (vin_tuser),
      .s_tlast    (vin_tlast),
      .mw_valid   (wreq_valid),
      .mw_ready   (wreq_ready),
      .mw_addr    (wreq_addr),
      .mw_data    (wreq_data),
      .len_err    (wr_len_err),
      .next_idx   (wr_next_w),
      .done       (wr_done_w),
      .done_idx   (done_idx_w),
      .busy       (wr_busy_w),
      .cur_idx    (wr_idx_w)
   );

   fbuf_rd_chan #(
      .ADDR_W (ADDR_W), .LEN_W (LEN_W), .LINE_W (LINE_W), .NBUF (NBUF)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (rd_run),
      .base       (rd_base),
      .cfg_len    (rd_line_bytes),
      .cfg_stride (rd_stride),
      .cfg_lines  (rd_lines),
      .avail      (done_vld_w),
      .pick_idx   (last_done_w),
      .mr_valid   (rreq_valid),
      .mr_ready   (rreq_ready),
      .mr_addr    (rreq_addr),
      .mr_sof     (rreq_sof),
      .mr_eol     (rreq_eol),
      .busy       (rd_busy_w),
      .cur_idx    (rd_idx_w)
   );
endmodule

// File: rtl/fbuf_addr_ctrl_chk.sv
module fbuf_addr_ctrl_chk
   import fbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NBUF   = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NBUF-1:0][ADDR_W-1:0] wr_base,
   input logic                        vin_tuser,
   input logic                        wreq_valid,
   input logic [ADDR_W-1:0]           wreq_addr,
   input logic                        wr_len_err,
   input logic                        rreq_valid,
   input logic                        rreq_ready,
   input logic [ADDR_W-1:0]           rreq_addr,
   input logic                        wr_busy,
   input buf_idx_t                    wr_idx,
   input logic                        rd_busy,
   input buf_idx_t                    rd_idx,
   input buf_idx_t                    last_done
);
   logic [NBUF-1:0] base_hit;
   for (genvar g = 0; g < NBUF; g++) begin : g_hit
      assign base_hit[g] = (wreq_addr == wr_base[g]);
   end

   assert_no_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && rd_busy) |-> (wr_idx != rd_idx));

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_len_err |=> wr_len_err);

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rreq_valid && !rreq_ready) |=> (rreq_valid && $stable(rreq_addr)));

   assert_sof_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wreq_valid && vin_tuser) |-> (base_hit != '0));

   assert_rd_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_busy) |-> (rd_idx == $past(last_done)));
endmodule

bind fbuf_addr_ctrl fbuf_addr_ctrl_chk #(.ADDR_W(ADDR_W), .NBUF(NBUF)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_base    (wr_base),
   .vin_tuser  (vin_tuser),
   .wreq_valid (wreq_valid),
   .wreq_addr  (wreq_addr),
   .wr_len_err (wr_len_err),
   .rreq_valid (rreq_valid),
   .rreq_ready (rreq_ready),
   .rreq_addr  (rreq_addr),
   .wr_busy    (wr_busy_w),
   .wr_idx     (wr_idx_w),
   .rd_busy    (rd_busy_w),
   .rd_idx     (rd_idx_w),
   .last_done  (last_done_w)
);

// File: tb/fbuf_addr_ctrl_tb.sv
`timescale 1ns/1ps
module fbuf_addr_ctrl_tb_top;
   localparam int unsigned AW = 32, LW = 16, NW = 12, PW = 24, NB = 3;
   localparam logic [15:0] LEN = 16'd12, STR = 16'h20, STR2 = 16'h40;
   localparam logic [11:0] LINES = 12'd3;
   localparam int NPX = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                    wr_run, rd_run;
   logic [NB-1:0][AW-1:0]   bases;
   logic [LW-1:0]           wr_len, wr_str, rd_len, rd_str;
   logic [NW-1:0]           wr_lines, rd_lines;
   logic                    tvalid, tready, tuser, tlast;
   logic [PW-1:0]           tdata;
   logic                    wvalid, wready, err;
   logic [AW-1:0]           waddr, raddr;
   logic [PW-1:0]           wdata;
   logic                    rvalid, rready, rsof, reol;

   fbuf_addr_ctrl #(.ADDR_W(AW), .LEN_W(LW), .LINE_W(NW), .PIX_W(PW), .NBUF(NB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_run(wr_run), .wr_base(bases), .wr_line_bytes(wr_len), .wr_stride(wr_str), .wr_lines(wr_lines),
      .vin_tvalid(tvalid), .vin_tready(tready), .vin_tdata(tdata), .vin_tuser(tuser), .vin_tlast(tlast),
      .wreq_valid(wvalid), .wreq_ready(wready), .wreq_addr(waddr), .wreq_data(wdata), .wr_len_err(err),
      .rd_run(rd_run), .rd_base(bases), .rd_line_bytes(rd_len), .rd_stride(rd_str), .rd_lines(rd_lines),
      .rreq_valid(rvalid), .rreq_ready(rready), .rreq_addr(raddr), .rreq_sof(rsof), .rreq_eol(reol)
   );

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   int m_last = 2;
   bit m_rd_busy = 0;
   int m_rd = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_next();
      int c = (m_last + 1) % 3;
      if (m_rd_busy && c == m_rd) c = (c + 1) % 3;
      return c;
   endfunction

   task automatic idle_stream();
      @(negedge clk);
      tvalid = 0; tuser = 0; tlast = 0;
   endtask

   // sends nlines lines of npx pixels; expect_write selects address checks or drop checks
   task automatic send_frame(input int nlines, input int npx, input int buf_i, input logic [15:0] str,
                             input bit expect_write, input int chg_line, input string req);
      for (int l = 0; l < nlines; l++) begin
         for (int p = 0; p < npx; p++) begin
            @(negedge clk);
            if (l == chg_line && p == 0) wr_str = STR2;
            tvalid = 1; tuser = (l == 0 && p == 0); tlast = (p == npx - 1);
            tdata = 24'(l * 16 + p);
            #1;
            if (expect_write) begin
               logic [31:0] e = bases[buf_i] + 32'(l) * 32'(str) + 32'(p * 3);
               chk(wvalid && waddr == e && wdata == tdata, req, waddr, e);
            end else begin
               chk(!wvalid && tready, req, {30'd0, wvalid, tready}, 32'd1);
            end
            @(posedge clk);
         end
      end
      idle_stream();
   endtask

   task automatic write_full(input int buf_i, input string req);
      send_frame(3, NPX, buf_i, STR, 1, -1, req);
      m_last = buf_i;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_run = 1;
      @(negedge clk); rd_run = 0;
   endtask

   task automatic read_frame(input int buf_i, input bit toggle, input string req);
      int l = 0, p = 0, cyc = 0;
      bit fin = 0;
      while (!fin && cyc < 200) begin
         @(negedge clk);
         rready = toggle ? (cyc % 3 != 2) : 1'b1;
         #1;
         begin
            logic [31:0] e = bases[buf_i] + 32'(l) * 32'(STR) + 32'(p * 3);
            chk(rvalid && raddr == e, req, raddr, e);
            chk(rsof == (l == 0 && p == 0) && reol == (p == NPX - 1), "R8 sof/eol", {30'd0, rsof, reol},
                {30'd0, 1'(l == 0 && p == 0), 1'(p == NPX - 1)});
         end
         @(posedge clk);
         if (rready) begin
            if (p == NPX - 1) begin p = 0; l++; if (l == 3) fin = 1; end
            else p++;
         end
         cyc++;
      end
      @(negedge clk); rready = 0;
      #1 chk(!rvalid, "R6 reader idle after frame", {31'd0, rvalid}, 0);
   endtask

   task automatic t_reset();
      #1 chk(!wvalid && !rvalid && !err, "reset state", {29'd0, wvalid, rvalid, err}, 0);
      // R6: reader must wait while no frame has completed
      rd_run = 1;
      repeat (4) begin
         @(negedge clk); #1 chk(!rvalid, "R6 no read before first frame", {31'd0, rvalid}, 0);
      end
      rd_run = 0;
   endtask

   task automatic t_drop_outside();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); tvalid = 1; tuser = 0; tlast = (i == 2); #1;
         chk(!wvalid && tready, "R2 beat outside frame dropped", {30'd0, wvalid, tready}, 1);
         @(posedge clk);
      end
      idle_stream();
   endtask

   task automatic t_rotation();
      for (int f = 0; f < 4; f++) write_full(exp_next(), "R1/R3/R4 rotation address");
      chk(m_last == 0, "R1 rotation wraps", m_last, 0);
      @(negedge clk); #1 chk(!rvalid, "R10 reader off", {31'd0, rvalid}, 0);
   endtask

   task automatic t_wr_stop();
      wr_run = 0;
      send_frame(1, NPX, 0, STR, 0, -1, "R10 write run off");
      wr_run = 1;
      write_full(exp_next(), "R10 write run back on keeps rotation");
   endtask

   task automatic t_cfg_frame();
      int b = exp_next();
      send_frame(3, NPX, b, STR, 1, 1, "R9 stride held within frame");
      m_last = b;
      b = exp_next();
      send_frame(3, NPX, b, STR2, 1, -1, "R9 new stride next frame");
      m_last = b;
      wr_str = STR;
   endtask

   task automatic t_restart();
      int b = exp_next();
      send_frame(1, NPX, b, STR, 1, -1, "R11 partial frame");
      write_full(b, "R11 restart reuses buffer at line 0");
   endtask

   task automatic t_read(input string req);
      pulse_rd();
      m_rd_busy = 1; m_rd = m_last;
      read_frame(m_rd, 1, req);
      m_rd_busy = 0;
   endtask

   task automatic t_collision();
      logic [31:0] held;
      rready = 0;
      pulse_rd();
      m_rd_busy = 1; m_rd = m_last;
      #1 held = raddr;
      chk(rvalid && raddr == bases[m_rd], "R6 reader locks last done", raddr, bases[m_rd]);
      for (int f = 0; f < 3; f++) begin
         int b = exp_next();
         chk(b != m_rd, "R7 model skip", b, m_rd);
         write_full(b, "R7 writer skips reader buffer");
      end
      #1 chk(raddr == held, "R8 address held while stalled", raddr, held);
      read_frame(m_rd, 0, "R8 drain stalled frame");
      m_rd_busy = 0;
   endtask

   task automatic t_len_err();
      int b = exp_next();
      @(negedge clk); #1 chk(!err, "R5 no error before", {31'd0, err}, 0);
      send_frame(3, NPX - 1, b, STR, 1, -1, "R5 short lines");
      m_last = b;
      @(negedge clk); #1 chk(err, "R5 error raised", {31'd0, err}, 1);
      write_full(exp_next(), "R5 clean frame after error");
      @(negedge clk); #1 chk(err, "R5 error sticky", {31'd0, err}, 1);
   endtask

   initial begin
      wr_run = 1; rd_run = 0;
      bases[0] = 32'h0100_0000; bases[1] = 32'h0200_0000; bases[2] = 32'h0300_0000;
      wr_len = LEN; rd_len = LEN; wr_str = STR; rd_str = STR; wr_lines = LINES; rd_lines = LINES;
      tvalid = 0; tuser = 0; tlast = 0; tdata = 0; wready = 1; rready = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_drop_outside();
      t_rotation();
      t_wr_stop();
      t_cfg_frame();
      t_restart();
      t_read("R6/R8 reader on latest frame");
      t_collision();
      t_read("R6 reader picks newest after writer moved");
      t_len_err();
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule